// File: doc/BRIEF.md
# Exclusive Two-Level Line Cache Controller

This block serves line-sized read requests from a small direct-mapped first level (L1) and a larger two-way set-associative second level (L2). The two levels are kept exclusive, so a line address is valid in one level at most. A request is accepted on a valid/ready handshake with a line address. The controller checks L1 first. It checks L2 only when L1 misses, and it asks the backing memory for the line only when both levels miss.

When L1 misses and L2 hits, the two lines trade places. The requested line moves from L2 into L1, and the line it displaces from L1 moves into the L2 slot that was just emptied. When both levels miss, the line returned by memory goes into L1 and the displaced L1 line goes into L2. Any line pushed out of L2 by that write is discarded. Both levels hold lines of the same width, so an exchange is always one line for one line.

The design is behavioural: tags, valid bits and line data sit in register arrays. The sizes are parameters and are kept small.

Top module: `excl_cache_top`

## Requirements
- R1: An access that hits in L1 asserts `resp_valid` with the stored line in the cycle after acceptance. `req_ready` stays high and no memory request is made.
- R2: An access that misses in L1 and hits in L2 asserts `resp_valid` in the third cycle after acceptance. `req_ready` is low for the two cycles in between, and no memory request is made.
- R3: After an L2 hit, the requested line is in L1, so the next access to it hits in L1. The line it displaced from L1 is in L2, so an access to that line hits in L2.
- R4: An access that misses in both levels raises `mem_req_valid` with `mem_req_addr` equal to the requested line address. The request is held until `mem_resp_valid`. `resp_valid` follows in the next cycle and carries the memory data, and the line is placed in L1.
- R5: On a miss in both levels, a valid line displaced from L1 is written into L2, so a later access to it hits in L2.
- R6: An L2 write goes to an invalid way of the set if one exists. Otherwise it goes to the way written least recently. The line overwritten there is dropped, so a later access to it requests memory.
- R7: A line address is never valid in L1 and L2 at the same time.
- R8: After reset, `req_ready` is high, `resp_valid` and `mem_req_valid` are low, and every line is invalid, so the first access misses in both levels.
- R9: The L1 index is the low `L1_IDX_W` bits of the line address and the L2 set is the low `L2_IDX_W` bits, with `L2_IDX_W` no larger than `L1_IDX_W`. Lines with different L1 indices coexist in L1.
- R10: Both levels store lines of `8*LINE_BYTES` bits (512 bits by default). Every response returns the full line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Line address of the request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | 8*LINE_BYTES | Returned line |
| mem_req_valid | output | 1 | Backing memory read request, held until answered |
| mem_req_addr | output | ADDR_W | Line address requested from memory |
| mem_resp_valid | input | 1 | Memory data present |
| mem_resp_data | input | 8*LINE_BYTES | Line returned by memory |

## Verification
The bench drives sequences of line addresses that all share one L1 index. It classifies each access as an L1 hit, an L2 hit or a full miss from two observations: the response latency, and whether a memory request appeared. That classification shows whether a swap moved both lines and whether a fill pushed its victim down into L2. Longer conflict runs fill both L2 ways and then force evictions, which tells apart a correct replacement-way choice from a wrong one and shows that dropped lines go back to memory. Accesses to a second index check that sets stay independent. Every response is compared against a line pattern derived from its address.

// File: rtl/excl_cache_pkg.sv
package excl_cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_L2CHK = 2'd1,
        ST_SWAP  = 2'd2,
        ST_MEM   = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/excl_l1_dir.sv
// Direct-mapped first level: one line per index, combinational lookup.
module excl_l1_dir #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int LINE_W = 512
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [ADDR_W-1:0]                      lk_addr,
    output logic                                   hit,
    output logic [LINE_W-1:0]                      rd_data,
    output logic                                   vic_valid,
    output logic [ADDR_W-1:0]                      vic_addr,
    input  logic                                   wr_en,
    input  logic [ADDR_W-1:0]                      wr_addr,
    input  logic [LINE_W-1:0]                      wr_data,
    output logic [(1<<IDX_W)-1:0]                  vld_vec,
    output logic [(1<<IDX_W)-1:0][ADDR_W-IDX_W-1:0] tag_vec
);
    localparam int SETS  = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic [SETS-1:0]             vld;
        logic [SETS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][LINE_W-1:0] dat;
    } l1_st_t;

    l1_st_t st_d, st_q;
    logic [IDX_W-1:0] lk_idx, wr_idx;

    always_comb begin
        st_d   = st_q;
        wr_idx = wr_addr[IDX_W-1:0];
        if (wr_en) begin
            st_d.vld[wr_idx] = 1'b1;
            st_d.tag[wr_idx] = wr_addr[ADDR_W-1:IDX_W];
            st_d.dat[wr_idx] = wr_data;
        end
        lk_idx    = lk_addr[IDX_W-1:0];
        vic_valid = st_q.vld[lk_idx];
        hit       = st_q.vld[lk_idx] && (st_q.tag[lk_idx] == lk_addr[ADDR_W-1:IDX_W]);
        rd_data   = st_q.dat[lk_idx];
        vic_addr  = {st_q.tag[lk_idx], lk_idx};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < SETS; i++) begin : g_out
        assign vld_vec[i] = st_q.vld[i];
        assign tag_vec[i] = st_q.tag[i];
    end
endmodule

// File: rtl/excl_l2_sets.sv
// Two-way set-associative second level with one replacement bit per set.
module excl_l2_sets #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int LINE_W = 512
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [ADDR_W-1:0]                          lk_addr,
    output logic                                       hit,
    output logic                                       hit_way,
    output logic [LINE_W-1:0]                          hit_data,
    output logic                                       vic_way,
    input  logic                                       wr_en,
    input  logic [ADDR_W-1:0]                          wr_addr,
    input  logic                                       wr_way,
    input  logic                                       wr_valid,
    input  logic [LINE_W-1:0]                          wr_data,
    output logic [(2<<IDX_W)-1:0]                      vld_vec,
    output logic [(2<<IDX_W)-1:0][ADDR_W-IDX_W-1:0]    tag_vec
);
    localparam int SETS  = 1 << IDX_W;
    localparam int WAYS  = 2;
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][LINE_W-1:0] dat;
        logic [SETS-1:0]                       repl; // way to overwrite next
    } l2_st_t;

    l2_st_t st_d, st_q;
    logic [IDX_W-1:0] lk_set, wr_set;
    logic [WAYS-1:0]  way_hit;

    assign lk_set = lk_addr[IDX_W-1:0];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = st_q.vld[lk_set][w] &&
                            (st_q.tag[lk_set][w] == lk_addr[ADDR_W-1:IDX_W]);
    end

    always_comb begin
        st_d     = st_q;
        wr_set   = wr_addr[IDX_W-1:0];
        if (wr_en) begin
            st_d.vld[wr_set][wr_way] = wr_valid;
            st_d.tag[wr_set][wr_way] = wr_addr[ADDR_W-1:IDX_W];
            st_d.dat[wr_set][wr_way] = wr_data;
            st_d.repl[wr_set]        = ~wr_way;
        end
        hit      = |way_hit;
        hit_way  = way_hit[1];
        hit_data = st_q.dat[lk_set][hit_way];
        if (!st_q.vld[lk_set][0])      vic_way = 1'b0;
        else if (!st_q.vld[lk_set][1]) vic_way = 1'b1;
        else                           vic_way = st_q.repl[lk_set];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign vld_vec[s*WAYS+w] = st_q.vld[s][w];
            assign tag_vec[s*WAYS+w] = st_q.tag[s][w];
        end
    end
endmodule

// File: rtl/excl_cache_top.sv
module excl_cache_top
    import excl_cache_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int L1_IDX_W   = 2,
    parameter int L2_IDX_W   = 2,
    parameter int LINE_BYTES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    resp_valid,
    output logic [8*LINE_BYTES-1:0] resp_data,
    output logic                    mem_req_valid,
    output logic [ADDR_W-1:0]       mem_req_addr,
    input  logic                    mem_resp_valid,
    input  logic [8*LINE_BYTES-1:0] mem_resp_data
);
    localparam int LINE_W  = 8 * LINE_BYTES;
    localparam int L1_SETS = 1 << L1_IDX_W;
    localparam int L2_ENTS = 2 << L2_IDX_W;
    localparam int T1_W    = ADDR_W - L1_IDX_W;
    localparam int T2_W    = ADDR_W - L2_IDX_W;

    typedef struct packed {
        ctl_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              resp_v;
        logic [LINE_W-1:0] resp_data;
    } ctl_t;

    ctl_t cur_d, cur_q;

    logic [ADDR_W-1:0] lk_addr;
    logic              l1_hit, l1_vic_valid, l1_we;
    logic [LINE_W-1:0] l1_data, l1_wdata;
    logic [ADDR_W-1:0] l1_vic_addr;
    logic              l2_hit, l2_hit_way, l2_vic_way;
    logic [LINE_W-1:0] l2_hit_data;
    logic              l2_we, l2_wway, l2_wvalid;
    logic [ADDR_W-1:0] l2_waddr;

    logic [L1_SETS-1:0]            l1_vld_vec;
    logic [L1_SETS-1:0][T1_W-1:0]  l1_tag_vec;
    logic [L2_ENTS-1:0]            l2_vld_vec;
    logic [L2_ENTS-1:0][T2_W-1:0]  l2_tag_vec;
    ctl_state_e                    ctl_state;

    assign ctl_state = cur_q.state;
    assign lk_addr   = (cur_q.state == ST_IDLE) ? req_addr : cur_q.addr;

    excl_l1_dir #(.ADDR_W(ADDR_W), .IDX_W(L1_IDX_W), .LINE_W(LINE_W)) u_l1 (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
        .hit(l1_hit), .rd_data(l1_data),
        .vic_valid(l1_vic_valid), .vic_addr(l1_vic_addr),
        .wr_en(l1_we), .wr_addr(cur_q.addr), .wr_data(l1_wdata),
        .vld_vec(l1_vld_vec), .tag_vec(l1_tag_vec)
    );

    excl_l2_sets #(.ADDR_W(ADDR_W), .IDX_W(L2_IDX_W), .LINE_W(LINE_W)) u_l2 (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
        .hit(l2_hit), .hit_way(l2_hit_way), .hit_data(l2_hit_data),
        .vic_way(l2_vic_way),
        .wr_en(l2_we), .wr_addr(l2_waddr), .wr_way(l2_wway),
        .wr_valid(l2_wvalid), .wr_data(l1_data),
        .vld_vec(l2_vld_vec), .tag_vec(l2_tag_vec)
    );

    always_comb begin
        cur_d        = cur_q;
        cur_d.resp_v = 1'b0;
        l1_we        = 1'b0;
        l1_wdata     = l2_hit_data;
        l2_we        = 1'b0;
        l2_waddr     = l1_vic_addr;   // victim shares the L2 set of the request
        l2_wway      = l2_hit_way;
        l2_wvalid    = l1_vic_valid;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    cur_d.addr = req_addr;
                    if (l1_hit) begin
                        cur_d.resp_v    = 1'b1;
                        cur_d.resp_data = l1_data;
                    end else begin
                        cur_d.state = ST_L2CHK;
                    end
                end
            end
            ST_L2CHK: cur_d.state = l2_hit ? ST_SWAP : ST_MEM;
            ST_SWAP: begin
                // exchange: L2 line into L1, L1 victim into the freed way
                l1_we           = 1'b1;
                l2_we           = 1'b1;
                cur_d.resp_v    = 1'b1;
                cur_d.resp_data = l2_hit_data;
                cur_d.state     = ST_IDLE;
            end
            ST_MEM: begin
                if (mem_resp_valid) begin
                    l1_we           = 1'b1;
                    l1_wdata        = mem_resp_data;
                    l2_we           = l1_vic_valid;
                    l2_wway         = l2_vic_way;
                    l2_wvalid       = 1'b1;
                    cur_d.resp_v    = 1'b1;
                    cur_d.resp_data = mem_resp_data;
                    cur_d.state     = ST_IDLE;
                end
            end
            default: cur_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign req_ready     = (cur_q.state == ST_IDLE);
    assign resp_valid    = cur_q.resp_v;
    assign resp_data     = cur_q.resp_data;
    assign mem_req_valid = (cur_q.state == ST_MEM);
    assign mem_req_addr  = cur_q.addr;
endmodule

// File: rtl/excl_cache_chk.sv
module excl_cache_chk
    import excl_cache_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int L1_IDX_W = 2,
    parameter int L2_IDX_W = 2
) (
    input logic                                          clk,
    input logic                                          rst_n,
    input ctl_state_e                                    ctl_state,
    input logic                                          req_valid,
    input logic                                          req_ready,
    input logic                                          resp_valid,
    input logic                                          mem_req_valid,
    input logic [ADDR_W-1:0]                             mem_req_addr,
    input logic                                          mem_resp_valid,
    input logic                                          l1_hit,
    input logic                                          l2_hit,
    input logic [(1<<L1_IDX_W)-1:0]                      l1_vld_vec,
    input logic [(1<<L1_IDX_W)-1:0][ADDR_W-L1_IDX_W-1:0] l1_tag_vec,
    input logic [(2<<L2_IDX_W)-1:0]                      l2_vld_vec,
    input logic [(2<<L2_IDX_W)-1:0][ADDR_W-L2_IDX_W-1:0] l2_tag_vec
);
    localparam int L1_SETS = 1 << L1_IDX_W;

    logic              dup;
    logic [ADDR_W-1:0] full;
    int                s;

    always_comb begin
        dup  = 1'b0;
        full = '0;
        s    = 0;
        for (int i = 0; i < L1_SETS; i++) begin
            full = {l1_tag_vec[i], L1_IDX_W'(i)};
            s    = int'(full[L2_IDX_W-1:0]);
            for (int w = 0; w < 2; w++) begin
                if (l1_vld_vec[i] && l2_vld_vec[s*2+w] &&
                    (l2_tag_vec[s*2+w] == full[ADDR_W-1:L2_IDX_W]))
                    dup = 1'b1;
            end
        end
    end

    assert_unique_line_R7: assert property (@(posedge clk) disable iff (!rst_n) !dup);

    assert_l1_hit_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && l1_hit) |=> (resp_valid && req_ready && !mem_req_valid));

    assert_l1_miss_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !l1_hit) |=> (!req_ready && !resp_valid));

    assert_swap_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_L2CHK && l2_hit) |=> (!resp_valid && !req_ready && !mem_req_valid));

    assert_swap_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_SWAP) |=> (resp_valid && req_ready));

    assert_mem_on_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(ctl_state == ST_L2CHK && !l2_hit));

    assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_resp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_mem_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_resp_valid) |=> (resp_valid && !mem_req_valid));
endmodule

bind excl_cache_top excl_cache_chk #(
    .ADDR_W(ADDR_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_state(ctl_state),
    .req_valid(req_valid), .req_ready(req_ready), .resp_valid(resp_valid),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .l1_hit(l1_hit), .l2_hit(l2_hit),
    .l1_vld_vec(l1_vld_vec), .l1_tag_vec(l1_tag_vec),
    .l2_vld_vec(l2_vld_vec), .l2_tag_vec(l2_tag_vec)
);

// File: tb/excl_cache_top_test.sv
module excl_cache_top_test;
    localparam int AW = 8;
    localparam int LW = 512;
    localparam int K_L1 = 0, K_L2 = 1, K_MISS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          resp_valid;
    logic [LW-1:0] resp_data;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_resp_valid = 1'b0;
    logic [LW-1:0] mem_resp_data = '0;

    int n_chk = 0, n_fail = 0, mem_cnt = 0, cyc = 0;
    logic [AW-1:0] mem_last = '0;

    always #2.5 clk = ~clk;

    excl_cache_top #(.ADDR_W(AW), .L1_IDX_W(2), .L2_IDX_W(2), .LINE_BYTES(64)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
    );

    function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
        logic [LW-1:0] l;
        for (int w = 0; w < LW/32; w++) l[w*32 +: 32] = {8'hC3, a, 8'(w), ~a};
        return l;
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // backing memory: answers two cycles after it sees a request
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid && !mem_resp_valid) begin
                mem_cnt++;
                mem_last = mem_req_addr;
                @(negedge clk);
                @(negedge clk);
                mem_resp_valid = 1'b1;
                mem_resp_data  = line_of(mem_last);
                @(negedge clk);
                mem_resp_valid = 1'b0;
            end
        end
    end

    // one access; kind is the expected outcome derived from the requirements
    task automatic access(input logic [AW-1:0] a, input int kind, input string rq);
        int m0, lat;
        bit busy_low;
        m0 = mem_cnt;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        busy_low = !req_ready;
        while (!resp_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check(resp_data == line_of(a), "R10", "line data", resp_data, line_of(a));
        if (kind == K_L1) begin
            check(lat == 1 && !busy_low, rq, "L1 hit latency/ready", LW'(lat), LW'(1));
            check(mem_cnt == m0, rq, "L1 hit memory requests", LW'(mem_cnt - m0), '0);
        end else if (kind == K_L2) begin
            check(lat == 3 && busy_low, rq, "L2 hit latency/ready", LW'(lat), LW'(3));
            check(mem_cnt == m0, rq, "L2 hit memory requests", LW'(mem_cnt - m0), '0);
        end else begin
            check(mem_cnt == m0 + 1, rq, "miss memory requests", LW'(mem_cnt - m0), LW'(1));
            check(mem_last == a, rq, "miss memory address", LW'(mem_last), LW'(a));
            check(lat == 5, rq, "miss latency", LW'(lat), LW'(5));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R8", "ready after reset", LW'(req_ready), LW'(1));
        check(resp_valid == 1'b0, "R8", "resp_valid after reset", LW'(resp_valid), '0);
        check(mem_req_valid == 1'b0, "R8", "mem_req_valid after reset", LW'(mem_req_valid), '0);
    endtask

    task automatic t_fill_and_hit();
        access(8'h01, K_MISS, "R8");   // everything invalid after reset
        access(8'h01, K_L1, "R1");     // R4: fetched line now in L1
    endtask

    task automatic t_swap();
        access(8'h05, K_MISS, "R4");   // 01 pushed down into L2 (R5)
        access(8'h01, K_L2, "R5");     // R2 timing, swap with 05
        access(8'h01, K_L1, "R3");     // requested line moved up
        access(8'h05, K_L2, "R3");     // displaced line moved down, not lost (R7)
    endtask

    task automatic t_replace();
        // L1={05}, L2 set1={01,-}
        access(8'h09, K_MISS, "R6");   // 05 into invalid way: L2={01,05}
        access(8'h0D, K_MISS, "R6");   // 09 evicts 01 (older write)
        access(8'h01, K_MISS, "R6");   // 01 was dropped; 0D evicts 05
        access(8'h09, K_L2, "R6");     // 09 survived both evictions
        access(8'h05, K_MISS, "R6");   // 05 was dropped
    endtask

    task automatic t_indices();
        access(8'h02, K_MISS, "R9");
        access(8'h05, K_L1, "R9");     // index 1 untouched by index 2
        access(8'h06, K_MISS, "R9");   // same index as 02
        access(8'h02, K_L2, "R9");
        access(8'h06, K_L2, "R7");     // 06 exactly in L2, not duplicated
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_and_hit();
        t_swap();
        t_replace();
        t_indices();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule